// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans up one asynchronous digital input before it reaches edge-detection logic. The raw pin is first brought into the system clock domain through a two-stage synchronizer. A 5-bit up counter then measures how long a new level has held against the currently accepted level. The new level is accepted and shown at the output only when the counter completes the range chosen by a 4-bit one-hot filter field. A level that falls back before that point is treated as a glitch: the count is thrown away and the output does not move.

The counter advances either on every system clock or only on an external prescaled clock-enable pulse, as chosen by a select input. The outputs are the accepted level, a one-cycle edge strobe in the cycle in which that level changes, and a flag that tells whether the change was a rise or a fall.

Top module: `input_glitch_filter`

## Requirements
- R1: The pin passes through two synchronizer flip-flops. In bypass mode `level_o` takes a new pin value at the second rising clock edge after the pin changes, and holds it from then on.
- R2: `filt_sel` = 4'b0000 selects bypass. 4'b0001, 4'b0010, 4'b0100 and 4'b1000 need 2, 4, 8 and 16 count ticks. Any value with no bit set or with more than one bit set behaves exactly like bypass.
- R3: In a filtering mode that needs N ticks, with a tick on every clock, a new pin level that holds for N or more clocks is accepted. `level_o` takes the new value at the (N+2)th rising edge after the pin changes.
- R4: A pin pulse that lasts fewer clocks than the N ticks the mode needs leaves `level_o` unchanged and produces no edge strobe.
- R5: When the synchronized input returns to the accepted level, the count clears. Two short pulses separated by a single cycle at the old level do not add up to an acceptance.
- R6: With `use_prescale` = 1 the counter advances only in cycles where `tick_en` is high. With `tick_en` held low a changed level is never accepted, and the level is accepted at the clock edge that carries the Nth tick.
- R7: `edge_o` is high for exactly the one cycle in which `level_o` differs from its previous value, and is low in every other cycle. While `edge_o` is high, `edge_rise_o` equals the new level: 1 for a rise, 0 for a fall.
- R8: While `rst_n` is low, `level_o` is loaded from the synchronized input, the count is cleared and `edge_o` is held low. After reset is released the output shows the held pin level with no edge strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_async | input | 1 | Raw asynchronous input to be filtered |
| use_prescale | input | 1 | 1: count only on `tick_en`; 0: count every clock |
| tick_en | input | 1 | Prescaled clock-enable pulse, one cycle wide |
| filt_sel | input | 4 | One-hot qualification length; non-one-hot selects bypass |
| level_o | output | 1 | Filtered, accepted input level |
| edge_o | output | 1 | One-cycle strobe when `level_o` changes |
| edge_rise_o | output | 1 | Direction of the change: 1 for a rise, 0 for a fall |

## Verification
In bypass mode a pin change is due at `level_o` after the second rising edge. In a filtering mode that counts every clock it is due after rising edge N+2. In prescaled mode it is due at the edge that carries the Nth `tick_en`, and `edge_o` is high only in that first cycle. The bench drives every input at the falling edge and counts rising edges from the pin change. It samples once just before the due edge, where the old value must still be present, and once just after it. For each pulse-length vector it counts edge strobes over a long settling window, so that glitch rejection is judged by the outputs and not by an internal count.

// File: rtl/input_glitch_filter_pkg.sv
// Package: shared sizing for the input glitch filter.
// Assumes: the select field is one-hot, and the largest tick count
// (2 << (FILT_SEL_W-1)) minus one fits in CNT_W bits.
package input_glitch_filter_pkg;
    localparam int unsigned FILT_SEL_W = 4;
    localparam int unsigned CNT_W      = 5;
    localparam int unsigned SYNC_DEPTH = 2;

    // Decoded filter configuration handed from decoder to qualifier.
    typedef struct packed {
        logic             bypass;
        logic [CNT_W-1:0] term;   // count value at which the next tick accepts
    } filt_cfg_t;
endpackage

// File: rtl/gf_sync.sv
// Module: gf_sync
// Brings the raw pin into the clock domain through a chain of STAGES
// flip-flops. Gives the last stage (q) and the stage before it (pre).
// Assumes: STAGES >= 2. The stages are deliberately not reset, so the
// chain keeps sampling during reset and the qualifier can load from it.
module gf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic pre,
    output logic q
);
    logic [STAGES-1:0] chain;

    // First stage captures the asynchronous pin.
    always_ff @(posedge clk) begin
        chain[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Each further stage re-times the previous one.
        always_ff @(posedge clk) begin
            chain[g] <= chain[g-1];
        end
    end

    assign pre = chain[STAGES-2];
    assign q   = chain[STAGES-1];
endmodule

// File: rtl/gf_mode_decode.sv
// Module: gf_mode_decode
// Turns the one-hot filter field into a bypass flag and a terminal count.
// Bit i set means 2 << i ticks are needed (terminal count (2 << i) - 1).
// No bit set, or more than one bit set, selects bypass.
// Assumes: (2 << (SEL_W-1)) - 1 fits in CNT_W bits.
module gf_mode_decode
    import input_glitch_filter_pkg::*;
#(
    parameter int unsigned SEL_W = FILT_SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output filt_cfg_t        cfg
);
    // Pure decode of the select field into the mode and the terminal count.
    always_comb begin
        cfg.bypass = 1'b1;
        cfg.term   = '0;
        if ($countones(sel) == 1) begin
            cfg.bypass = 1'b0;
            for (int i = 0; i < int'(SEL_W); i++) begin
                if (sel[i]) cfg.term = CNT_W'((2 << i) - 1);
            end
        end
    end
endmodule

// File: rtl/gf_qualify.sv
// Module: gf_qualify
// Holds the accepted level and the qualification counter. A differing
// synchronized level is counted on each tick. When the count reaches the
// terminal value on a tick, the level is accepted and a one-cycle edge
// strobe is raised. A return to the accepted level clears the count.
// In bypass the level follows the stage before the last synchronizer
// flip-flop, so the total latency matches the plain two-stage sync.
module gf_qualify
    import input_glitch_filter_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pre,
    input  logic             sync_lvl,
    input  logic             tick,
    input  filt_cfg_t        cfg,
    output logic             level,
    output logic             edge_p,
    output logic             rise,
    output logic [CNT_W-1:0] cnt
);
    // Level, strobe, direction and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level  <= sync_lvl;
            cnt    <= '0;
            edge_p <= 1'b0;
            rise   <= 1'b0;
        end else if (cfg.bypass) begin
            level  <= sync_pre;
            edge_p <= (sync_pre != level);
            rise   <= sync_pre;
            cnt    <= '0;
        end else if (sync_lvl == level) begin
            cnt    <= '0;
            edge_p <= 1'b0;
        end else if (tick) begin
            if (cnt >= cfg.term) begin
                level  <= sync_lvl;
                edge_p <= 1'b1;
                rise   <= sync_lvl;
                cnt    <= '0;
            end else begin
                cnt    <= cnt + 1'b1;
                edge_p <= 1'b0;
            end
        end else begin
            edge_p <= 1'b0;
        end
    end
endmodule

// File: rtl/input_glitch_filter.sv
// Module: input_glitch_filter (top)
// Synchronizes one pin, decodes the filter field and qualifies level
// changes against a masked up counter, with a selectable count clock.
// Assumes: tick_en is a one-cycle pulse in the clk domain.
module input_glitch_filter
    import input_glitch_filter_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pin_async,
    input  logic                  use_prescale,
    input  logic                  tick_en,
    input  logic [FILT_SEL_W-1:0] filt_sel,
    output logic                  level_o,
    output logic                  edge_o,
    output logic                  edge_rise_o
);
    logic             sync_pre;
    logic             sync_q;
    logic             tick_w;
    filt_cfg_t        cfg_w;
    logic             bypass_w;
    logic [CNT_W-1:0] cnt_q;

    gf_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .d   (pin_async),
        .pre (sync_pre),
        .q   (sync_q)
    );

    gf_mode_decode #(.SEL_W(FILT_SEL_W)) u_dec (
        .sel (filt_sel),
        .cfg (cfg_w)
    );

    // Count-clock selection: every cycle, or the prescaled enable only.
    assign tick_w   = use_prescale ? tick_en : 1'b1;
    assign bypass_w = cfg_w.bypass;

    gf_qualify u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_pre (sync_pre),
        .sync_lvl (sync_q),
        .tick     (tick_w),
        .cfg      (cfg_w),
        .level    (level_o),
        .edge_p   (edge_o),
        .rise     (edge_rise_o),
        .cnt      (cnt_q)
    );
endmodule

// File: rtl/input_glitch_filter_checker.sv
// Module: input_glitch_filter_checker
// Temporal checks on the filter, attached to the top by bind.
module input_glitch_filter_checker
    import input_glitch_filter_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             use_prescale,
    input logic             tick_en,
    input logic             level_o,
    input logic             edge_o,
    input logic             edge_rise_o,
    input logic             sync_lvl,
    input logic             bypass,
    input logic [CNT_W-1:0] cnt
);
    assert_edge_marks_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> (level_o != $past(level_o)));

    assert_change_has_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (level_o != $past(level_o))) |-> edge_o);

    assert_rise_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> (edge_rise_o == level_o));

    assert_accept_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o && $past(rst_n) && !$past(bypass)) |-> $past(use_prescale ? tick_en : 1'b1));

    assert_clear_on_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && (sync_lvl == level_o)) |=> (cnt == '0));

    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |=> !edge_o);
endmodule

bind input_glitch_filter input_glitch_filter_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .use_prescale (use_prescale),
    .tick_en      (tick_en),
    .level_o      (level_o),
    .edge_o       (edge_o),
    .edge_rise_o  (edge_rise_o),
    .sync_lvl     (sync_q),
    .bypass       (bypass_w),
    .cnt          (cnt_q)
);

// File: tb/input_glitch_filter_tb.sv
`timescale 1ns/1ps
module input_glitch_filter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_async = 1'b0;
    logic       use_prescale = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] filt_sel = 4'b0000;
    logic       level_o, edge_o, edge_rise_o;

    int n_checks = 0;
    int n_fails  = 0;
    int edge_cnt = 0;

    always #2.5 clk = ~clk;

    input_glitch_filter u_dut (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
        .use_prescale(use_prescale), .tick_en(tick_en), .filt_sel(filt_sel),
        .level_o(level_o), .edge_o(edge_o), .edge_rise_o(edge_rise_o)
    );

    // Counts edge strobes, sampled away from the active edge.
    always @(negedge clk) if (edge_o) edge_cnt++;

    // Vector: sel[12:9], pulse length[8:2], expected strobes[1:0].
    localparam int NV = 11;
    localparam logic [12:0] VEC [NV] = '{
        {4'b0000, 7'd1,  2'd2},   // R2 bypass: any pulse passes
        {4'b0001, 7'd1,  2'd0},   // R4 short for N=2
        {4'b0001, 7'd2,  2'd2},   // R3 exactly N=2
        {4'b0010, 7'd3,  2'd0},   // R4
        {4'b0010, 7'd4,  2'd2},   // R3
        {4'b0100, 7'd7,  2'd0},   // R4
        {4'b0100, 7'd8,  2'd2},   // R3
        {4'b1000, 7'd15, 2'd0},   // R4
        {4'b1000, 7'd16, 2'd2},   // R3
        {4'b0110, 7'd1,  2'd2},   // R2 two bits set: bypass
        {4'b1000, 7'd20, 2'd2}    // R3 longer than N
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Raise the pin and check that level_o changes exactly at posedge k.
    task automatic timing(input string req, input logic [3:0] sel, input int k);
        filt_sel = sel;
        cycles(40);
        pin_async = 1'b1;
        repeat (k - 1) @(posedge clk);
        @(negedge clk);
        check({req, " level before due edge"}, int'(level_o), 0);
        @(posedge clk); @(negedge clk);
        check({req, " level at due edge"}, int'(level_o), 1);
        check({req, " strobe at due edge"}, int'(edge_o), 1);
        check({req, " rise flag"}, int'(edge_rise_o), 1);
        @(posedge clk); @(negedge clk);
        check({req, " strobe one cycle"}, int'(edge_o), 0);
        pin_async = 1'b0;
        cycles(40);
        check({req, " returned low"}, int'(level_o), 0);
    endtask

    task automatic run_all();
        // R8: reset with the pin held high.
        pin_async = 1'b1;
        cycles(5);
        check("R8 strobe low in reset", int'(edge_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 level from pin after reset", int'(level_o), 1);
        check("R8 no strobe after reset", int'(edge_o), 0);
        pin_async = 1'b0;
        cycles(40);
        check("R7 fall accepted", int'(level_o), 0);

        // Table walk: pulse length vs. mode (ticks every cycle).
        for (int v = 0; v < NV; v++) begin
            filt_sel = VEC[v][12:9];
            cycles(40);
            edge_cnt = 0;
            pin_async = 1'b1;
            cycles(int'(VEC[v][8:2]));
            pin_async = 1'b0;
            cycles(40);
            check($sformatf("R3/R4 strobes vec %0d", v), edge_cnt, int'(VEC[v][1:0]));
            check($sformatf("R4 final level vec %0d", v), int'(level_o), 0);
        end

        // R1/R2: bypass latency is two edges, for both bypass encodings.
        timing("R1 bypass", 4'b0000, 2);
        timing("R2 invalid sel", 4'b0101, 2);
        // R3: filtered latency N+2 edges.
        timing("R3 N=2", 4'b0001, 4);
        timing("R3 N=16", 4'b1000, 18);

        // R5: 3 high, 1 low, 3 high with N=4 must not accumulate.
        filt_sel = 4'b0010;
        cycles(40);
        edge_cnt = 0;
        pin_async = 1'b1; cycles(3);
        pin_async = 1'b0; cycles(1);
        pin_async = 1'b1; cycles(3);
        pin_async = 1'b0; cycles(40);
        check("R5 split pulse rejected", edge_cnt, 0);

        // R6: prescaled counting, N=2.
        filt_sel = 4'b0001;
        use_prescale = 1'b1;
        cycles(10);
        edge_cnt = 0;
        pin_async = 1'b1;
        cycles(30);
        check("R6 no tick no accept", int'(level_o), 0);
        tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
        cycles(3);
        check("R6 one tick not enough", int'(level_o), 0);
        tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
        check("R6 accepted on second tick", int'(level_o), 1);
        check("R6 strobe on second tick", int'(edge_o), 1);
        @(negedge clk);
        check("R7 strobe lasts one cycle", int'(edge_o), 0);
        check("R7 single strobe count", edge_cnt, 1);
        pin_async = 1'b0;
        cycles(10);
        tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
        tick_en = 1'b1; @(negedge clk); tick_en = 1'b0;
        check("R7 fall direction flag", int'(edge_rise_o), 0);
        check("R6 fall accepted", int'(level_o), 0);
        use_prescale = 1'b0;
        cycles(5);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule